// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Trap

This block is the integer execute stage of a load/store RISC core. It is purely combinational: two register operands, a 16-bit immediate, a 5-bit shift count and a decoded operation select go in. A 32-bit result, a trap flag and a write-permission flag come out in the same cycle. The core's decode stage picks the operation. The writeback stage uses the write-permission flag to decide whether the destination register is updated. The exception logic acts on the trap flag.

The block covers wrapped and overflow-checked addition and subtraction, the four bitwise operations, signed set-on-less-than, constant shifts and placing an immediate in the upper half of a word. Immediates are widened inside the block, sign- or zero-extended according to the operation. Shifts act on the second register operand. Select values outside the defined set give a zero result with no trap.

Top module: `alu_exec`

## Requirements
- R1: For OP_ADD (select 0) and OP_SUB (select 2), `result` is the sum or difference of `opnd_a` and `opnd_b`, wrapped to 32 bits. `ovf_trap` is 1 exactly when the signed two's-complement value overflows, and `wr_ok` is then 0.
- R2: OP_ADDU (1), OP_SUBU (3) and OP_ADDIU (5) give the same wrapped result as the trapping forms, keep `ovf_trap` at 0 and keep `wr_ok` at 1 for all operands.
- R3: OP_ADDI (4) and OP_ADDIU (5) add `opnd_a` to `imm` sign-extended from bit 15. OP_ADDI raises `ovf_trap` and clears `wr_ok` on signed overflow.
- R4: OP_AND (6), OP_OR (7), OP_XOR (8) and OP_NOR (9) combine the two register operands bit by bit. NOR yields the inverse of the OR.
- R5: OP_ANDI (10) and OP_ORI (11) combine `opnd_a` with `imm` zero-extended to 32 bits.
- R6: OP_SLT (12) and OP_SLTI (13) return 1 when `opnd_a` is less than the second value as signed numbers, and 0 otherwise. The second value is `opnd_b`, or `imm` sign-extended for OP_SLTI. Bits 31:1 of `result` are always 0.
- R7: OP_SLL (14) and OP_SRL (15) shift `opnd_b` left or right by `shamt` (0 to 31) and fill vacated bits with zeros.
- R8: OP_SRA (16) shifts `opnd_b` right by `shamt` and fills vacated bits with copies of bit 31.
- R9: OP_LUI (17) returns `imm` in bits 31:16 and zeros in bits 15:0.
- R10: Every operation other than OP_ADD, OP_SUB and OP_ADDI keeps `ovf_trap` at 0 and `wr_ok` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand; also the value that is shifted |
| imm | input | 16 | Immediate field of the instruction |
| shamt | input | 5 | Constant shift count |
| op_sel | input | 5 | Decoded operation select (values listed in the requirements) |
| result | output | 32 | Operation result, driven even when a trap is raised |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |
| wr_ok | output | 1 | Destination write permitted |

## Verification
The block holds no state, so any fault in the decode or a datapath appears at `result`, `ovf_trap` or `wr_ok` on the very inputs that expose it. The bench samples these outputs half a clock after driving the inputs. The faults most likely to slip by are the ones that act on only a few bit patterns. These are a wrong extension of the immediate (it shows only when bit 15 is set), a carry-based overflow instead of a signed one (it shows on the 0x7FFFFFFF+1 and 0x80000000-1 boundaries), a logical fill in place of a sign fill (it shows only on negative operands), and a compare that reads as unsigned (it shows only when the operand signs differ). Directed cases aim at each of these, and a random sweep compares every operation against a model built from the requirements.

// File: rtl/alu_exec_pkg.sv
// Shared types for the integer execute unit.
// Assumes the select encoding below is produced by the core's decoder.
package alu_exec_pkg;

    localparam int OP_W = 5;

    // Operation select; values are contiguous from 0.
    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADDU  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBU  = 5'd3,
        OP_ADDI  = 5'd4,
        OP_ADDIU = 5'd5,
        OP_AND   = 5'd6,
        OP_OR    = 5'd7,
        OP_XOR   = 5'd8,
        OP_NOR   = 5'd9,
        OP_ANDI  = 5'd10,
        OP_ORI   = 5'd11,
        OP_SLT   = 5'd12,
        OP_SLTI  = 5'd13,
        OP_SLL   = 5'd14,
        OP_SRL   = 5'd15,
        OP_SRA   = 5'd16,
        OP_LUI   = 5'd17
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_NOR
    } lg_kind_e;

    typedef enum logic [1:0] {
        SH_LL,
        SH_RL,
        SH_RA,
        SH_UPPER
    } sh_kind_e;

    typedef enum logic [1:0] {
        SRC_ARITH,
        SRC_LOGIC,
        SRC_SLT,
        SRC_SHIFT
    } res_src_e;

endpackage

// File: rtl/alu_addsub.sv
// Two's-complement adder/subtractor with signed overflow detection.
// Assumes: sub=1 selects a - b, computed as a + ~b + 1.
// Overflow is derived from operand and result sign bits, not from the carry.
module alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    output logic [XLEN-1:0] sum,
    output logic            ovf
);

    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] b_eff;

    // Form the second addend and the wrapped sum.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(XLEN-1){1'b0}}, sub};
    end

    // Signed overflow: like-signed addends give a result of the other sign.
    always_comb begin
        ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/alu_logic.sv
// Bitwise logic unit: and, or, xor, nor of two words.
// Assumes the caller has already widened any immediate operand.
module alu_logic #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]         a,
    input  logic [XLEN-1:0]         b,
    input  alu_exec_pkg::lg_kind_e  kind,
    output logic [XLEN-1:0]         res
);
    import alu_exec_pkg::*;

    // Select the bitwise function.
    always_comb begin
        case (kind)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = ~(a | b);
        endcase
    end

    // NOR output never shares a set bit with either operand.
    always_comb begin
        if (kind == LG_NOR) begin
            AST_NOR_DISJOINT: assert ((res & (a | b)) == '0) else $error("nor overlap"); // R4
        end
    end

endmodule

// File: rtl/alu_shift.sv
// Constant shifter plus upper-immediate placement.
// Assumes: shamt is below XLEN; SH_UPPER ignores val and shamt.
module alu_shift #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int SH_W  = 5
) (
    input  logic [XLEN-1:0]        val,
    input  logic [SH_W-1:0]        shamt,
    input  logic [IMM_W-1:0]       imm,
    input  alu_exec_pkg::sh_kind_e kind,
    output logic [XLEN-1:0]        res
);
    import alu_exec_pkg::*;

    localparam int LOW_W = XLEN - IMM_W;

    // Pick the shift flavour.
    always_comb begin
        case (kind)
            SH_LL:   res = val << shamt;
            SH_RL:   res = val >> shamt;
            SH_RA:   res = $unsigned($signed(val) >>> shamt);
            default: res = {imm, {LOW_W{1'b0}}};
        endcase
    end

    // Arithmetic right shift keeps the sign bit for every count.
    always_comb begin
        if (kind == SH_RA) begin
            AST_SRA_SIGN: assert (res[XLEN-1] == val[XLEN-1]) else $error("sra sign lost"); // R8
        end
    end

endmodule

// File: rtl/alu_exec.sv
// Integer execute unit: decodes the select, widens the immediate,
// and muxes the adder, logic and shift results.
// Assumes: combinational use in one core cycle; op_sel from the decoder.
// A trapping overflow still drives result but clears wr_ok.
module alu_exec #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    localparam int SH_W = $clog2(XLEN),
    localparam int OPW  = alu_exec_pkg::OP_W
) (
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    input  logic [IMM_W-1:0] imm,
    input  logic [SH_W-1:0]  shamt,
    input  logic [OPW-1:0]   op_sel,
    output logic [XLEN-1:0]  result,
    output logic             ovf_trap,
    output logic             wr_ok
);
    import alu_exec_pkg::*;

    localparam int EXT_W = XLEN - IMM_W;

    alu_op_e         op;
    logic            use_sx, use_zx, do_sub, trap_en, known;
    res_src_e        src;
    lg_kind_e        lg_kind;
    sh_kind_e        sh_kind;
    logic [XLEN-1:0] imm_sx, imm_zx, b_op;
    logic [XLEN-1:0] sum, lg_res, sh_res;
    logic            ovf, lt;

    // Decode the select into datapath controls.
    always_comb begin
        op      = alu_op_e'(op_sel);
        use_sx  = 1'b0;
        use_zx  = 1'b0;
        do_sub  = 1'b0;
        trap_en = 1'b0;
        known   = 1'b1;
        src     = SRC_ARITH;
        lg_kind = LG_AND;
        sh_kind = SH_LL;
        case (op)
            OP_ADD:   trap_en = 1'b1;
            OP_ADDU:  ;
            OP_SUB:   begin do_sub = 1'b1; trap_en = 1'b1; end
            OP_SUBU:  do_sub = 1'b1;
            OP_ADDI:  begin use_sx = 1'b1; trap_en = 1'b1; end
            OP_ADDIU: use_sx = 1'b1;
            OP_AND:   begin src = SRC_LOGIC; lg_kind = LG_AND; end
            OP_OR:    begin src = SRC_LOGIC; lg_kind = LG_OR;  end
            OP_XOR:   begin src = SRC_LOGIC; lg_kind = LG_XOR; end
            OP_NOR:   begin src = SRC_LOGIC; lg_kind = LG_NOR; end
            OP_ANDI:  begin src = SRC_LOGIC; lg_kind = LG_AND; use_zx = 1'b1; end
            OP_ORI:   begin src = SRC_LOGIC; lg_kind = LG_OR;  use_zx = 1'b1; end
            OP_SLT:   begin src = SRC_SLT; do_sub = 1'b1; end
            OP_SLTI:  begin src = SRC_SLT; do_sub = 1'b1; use_sx = 1'b1; end
            OP_SLL:   begin src = SRC_SHIFT; sh_kind = SH_LL; end
            OP_SRL:   begin src = SRC_SHIFT; sh_kind = SH_RL; end
            OP_SRA:   begin src = SRC_SHIFT; sh_kind = SH_RA; end
            OP_LUI:   begin src = SRC_SHIFT; sh_kind = SH_UPPER; end
            default:  known = 1'b0;
        endcase
    end

    // Widen the immediate and choose the second operand.
    always_comb begin
        imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
        imm_zx = {{EXT_W{1'b0}}, imm};
        b_op   = use_sx ? imm_sx : (use_zx ? imm_zx : opnd_b);
    end

    alu_addsub #(.XLEN(XLEN)) u_addsub (
        .a   (opnd_a),
        .b   (b_op),
        .sub (do_sub),
        .sum (sum),
        .ovf (ovf)
    );

    alu_logic #(.XLEN(XLEN)) u_logic (
        .a    (opnd_a),
        .b    (b_op),
        .kind (lg_kind),
        .res  (lg_res)
    );

    alu_shift #(.XLEN(XLEN), .IMM_W(IMM_W), .SH_W(SH_W)) u_shift (
        .val   (opnd_b),
        .shamt (shamt),
        .imm   (imm),
        .kind  (sh_kind),
        .res   (sh_res)
    );

    // Signed less-than from the difference sign, corrected by overflow.
    always_comb begin
        lt = sum[XLEN-1] ^ ovf;
    end

    // Final result mux and trap/write flags.
    always_comb begin
        if (!known) begin
            result = '0;
        end else begin
            case (src)
                SRC_ARITH: result = sum;
                SRC_LOGIC: result = lg_res;
                SRC_SLT:   result = {{(XLEN-1){1'b0}}, lt};
                default:   result = sh_res;
            endcase
        end
        ovf_trap = known & trap_en & ovf;
        wr_ok    = ~ovf_trap;
    end

    // Port-level checks on the decoded operation.
    always_comb begin
        if (op_sel == OP_SLT || op_sel == OP_SLTI) begin
            AST_SLT_BOOL: assert (result[XLEN-1:1] == '0) else $error("slt not boolean"); // R6
        end
        if (op_sel == OP_LUI) begin
            AST_LUI_LOW_ZERO: assert (result[EXT_W-1:0] == '0) else $error("lui low bits"); // R9
        end
        if (op_sel == OP_ADDU || op_sel == OP_SUBU || op_sel == OP_ADDIU) begin
            AST_UNSIGNED_NO_TRAP: assert (!ovf_trap && wr_ok) else $error("unsigned trapped"); // R2
        end
        if (op_sel != OP_ADD && op_sel != OP_SUB && op_sel != OP_ADDI) begin
            AST_NONARITH_NO_TRAP: assert (!ovf_trap) else $error("spurious trap"); // R10
        end
    end

endmodule

// File: tb/alu_exec_tb.sv
// Directed and random bench for alu_exec; expected values come from the requirements.
module alu_exec_tb;
    import alu_exec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a, opnd_b, result;
    logic [15:0] imm;
    logic [4:0]  shamt, op_sel;
    logic        ovf_trap, wr_ok;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    alu_exec u_dut (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .imm      (imm),
        .shamt    (shamt),
        .op_sel   (op_sel),
        .result   (result),
        .ovf_trap (ovf_trap),
        .wr_ok    (wr_ok)
    );

    function automatic string req_of(input alu_op_e op);
        case (op)
            OP_ADD, OP_SUB:             return "R1";
            OP_ADDU, OP_SUBU:           return "R2";
            OP_ADDI, OP_ADDIU:          return "R3";
            OP_AND, OP_OR, OP_XOR, OP_NOR: return "R4";
            OP_ANDI, OP_ORI:            return "R5";
            OP_SLT, OP_SLTI:            return "R6";
            OP_SLL, OP_SRL:             return "R7";
            OP_SRA:                     return "R8";
            default:                    return "R9";
        endcase
    endfunction

    // Reference model written from the requirement text.
    function automatic void ref_calc(input alu_op_e op, input logic [31:0] a, input logic [31:0] b,
                                     input logic [15:0] im, input logic [4:0] sh,
                                     output logic [31:0] r, output logic t);
        logic [31:0] sx, zx;
        longint      sa, sb, s;
        sx = {{16{im[15]}}, im};
        zx = {16'h0, im};
        sa = longint'($signed(a));
        t  = 1'b0;
        case (op)
            OP_ADD, OP_ADDU, OP_ADDI, OP_ADDIU: begin
                sb = (op == OP_ADDI || op == OP_ADDIU) ? longint'($signed(sx)) : longint'($signed(b));
                s  = sa + sb;
                r  = s[31:0];
                t  = (op != OP_ADDU && op != OP_ADDIU) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            OP_SUB, OP_SUBU: begin
                s = sa - longint'($signed(b));
                r = s[31:0];
                t = (op == OP_SUB) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_NOR:  r = ~(a | b);
            OP_ANDI: r = a & zx;
            OP_ORI:  r = a | zx;
            OP_SLT:  r = ($signed(a) < $signed(b))  ? 32'd1 : 32'd0;
            OP_SLTI: r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
            OP_SLL:  r = b << sh;
            OP_SRL:  r = b >> sh;
            OP_SRA:  begin
                r = b;
                for (int i = 0; i < 32; i++) if (i < int'(sh)) r = {b[31], r[31:1]};
            end
            default: r = {im, 16'h0};
        endcase
    endfunction

    // Drive one operation, sample half a cycle later, compare.
    task automatic run_op(input alu_op_e op, input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im, input logic [4:0] sh);
        logic [31:0] er;
        logic        et;
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; imm = im; shamt = sh;
        @(negedge clk);
        ref_calc(op, a, b, im, sh, er, et);
        checks++;
        if (result !== er || ovf_trap !== et || wr_ok !== !et) begin
            failures++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d: got res=%h trap=%b wr=%b exp res=%h trap=%b wr=%b",
                     req_of(op), op, a, b, im, sh, result, ovf_trap, wr_ok, er, et, !et);
        end
    endtask

    task automatic t_reset_state;   // R1 idle: add of zeros
        run_op(OP_ADD, 32'h0, 32'h0, 16'h0, 5'd0);
    endtask

    task automatic t_trap_add_sub;  // R1 boundaries
        run_op(OP_ADD, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0);
        run_op(OP_ADD, 32'h80000000, 32'h80000000, 16'h0, 5'd0);
        run_op(OP_ADD, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0);
        run_op(OP_SUB, 32'h80000000, 32'h1, 16'h0, 5'd0);
        run_op(OP_SUB, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0);
        run_op(OP_SUB, 32'h00000005, 32'h00000007, 16'h0, 5'd0);
    endtask

    task automatic t_unsigned_forms; // R2
        run_op(OP_ADDU, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0);
        run_op(OP_SUBU, 32'h80000000, 32'h1, 16'h0, 5'd0);
        run_op(OP_ADDIU, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0);
    endtask

    task automatic t_imm_add;        // R3 sign extension and trap
        run_op(OP_ADDI, 32'h00000010, 32'h0, 16'hFFFF, 5'd0);
        run_op(OP_ADDIU, 32'h00000000, 32'h0, 16'h8000, 5'd0);
        run_op(OP_ADDI, 32'h80000000, 32'h0, 16'hFFFF, 5'd0);
        run_op(OP_ADDI, 32'h7FFF8000, 32'h0, 16'h7FFF, 5'd0);
    endtask

    task automatic t_logic_reg;      // R4
        run_op(OP_AND, 32'hF0F0A5A5, 32'h0FF0FFFF, 16'hFFFF, 5'd3);
        run_op(OP_OR,  32'hF0F00000, 32'h0000A5A5, 16'h0, 5'd0);
        run_op(OP_XOR, 32'hFFFF0000, 32'hF0F0F0F0, 16'h0, 5'd0);
        run_op(OP_NOR, 32'h12345678, 32'h0F0F0000, 16'h0, 5'd0);
    endtask

    task automatic t_logic_imm;      // R5 zero extension
        run_op(OP_ANDI, 32'hFFFFFFFF, 32'h0, 16'h8001, 5'd0);
        run_op(OP_ORI,  32'h00000000, 32'hFFFFFFFF, 16'hF00F, 5'd0);
    endtask

    task automatic t_slt;            // R6 signed compare
        run_op(OP_SLT, 32'hFFFFFFFF, 32'h00000001, 16'h0, 5'd0);
        run_op(OP_SLT, 32'h00000001, 32'hFFFFFFFF, 16'h0, 5'd0);
        run_op(OP_SLT, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0);
        run_op(OP_SLT, 32'h00000004, 32'h00000004, 16'h0, 5'd0);
        run_op(OP_SLTI, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 5'd0);
        run_op(OP_SLTI, 32'h00000000, 32'h0, 16'h8000, 5'd0);
    endtask

    task automatic t_shift_logical;  // R7
        run_op(OP_SLL, 32'h0, 32'h80000001, 16'h0, 5'd0);
        run_op(OP_SLL, 32'h0, 32'h80000001, 16'h0, 5'd31);
        run_op(OP_SRL, 32'h0, 32'h80000000, 16'h0, 5'd31);
        run_op(OP_SRL, 32'h0, 32'hF0000000, 16'h0, 5'd4);
    endtask

    task automatic t_shift_arith;    // R8
        run_op(OP_SRA, 32'h0, 32'h80000000, 16'h0, 5'd31);
        run_op(OP_SRA, 32'h0, 32'hF0000000, 16'h0, 5'd0);
        run_op(OP_SRA, 32'h0, 32'h40000000, 16'h0, 5'd30);
    endtask

    task automatic t_upper_imm;      // R9
        run_op(OP_LUI, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hBEEF, 5'd7);
        run_op(OP_LUI, 32'h0, 32'h0, 16'h8000, 5'd0);
    endtask

    task automatic t_random_sweep;   // R10 and all: every op against the model
        for (int i = 0; i < 400; i++) begin
            run_op(alu_op_e'(5'($urandom_range(0, 17))), $urandom, $urandom,
                   16'($urandom), 5'($urandom));
        end
    endtask

    initial begin
        op_sel = '0; opnd_a = '0; opnd_b = '0; imm = '0; shamt = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_trap_add_sub();
        t_unsigned_forms();
        t_imm_add();
        t_logic_reg();
        t_logic_imm();
        t_slt();
        t_shift_logical();
        t_shift_arith();
        t_upper_imm();
        t_random_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, got hung exp done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule